// File: doc/BRIEF.md
# Byte-Wide Reprogrammable Flash Store

This block is a synthesizable behavioural model of a small byte-organised flash store that is reprogrammed by an external programmer. The pins are modelled as digital inputs: an active-low chip select, an active-low read enable and an active-low program strobe. There is also an address bus and a data bus, split here into an input byte, an output byte and an output-enable. The two high-voltage conditions a programmer applies are separate flag inputs. One marks the programming supply pin and the other marks address line 9.

The block works out the operating mode from these levels. The modes are standby, read, identification, byte program, chip erase and an inhibited state. It drives the data-bus output enable only for the two read modes. Program and erase pulses are timed in clock cycles. A program can only clear bits. Only a full-length erase pulse can return the whole array to all ones. A busy flag shows when a pulse is being timed.

Top module: `mtp_byte_store`

## Requirements
- R1: `dq_oe` is 1 exactly when `cen_n` = 0, `oen_n` = 0 and `hv_supply` = 0; otherwise the data bus is released (`dq_oe` = 0).
- R2: While `cen_n` = 1 the block is in standby: strobe pulses change no stored byte and `busy` is 0 from the cycle after `cen_n` is seen high.
- R3: With `hv_a9` = 1, `hv_supply` = 0 and a read enabled, `dq_out` is 0xBF when `addr[0]` = 0 and the parameter `DEV_CODE` when `addr[0]` = 1; `DEV_CODE` may only be 0xA4, 0xA5 or 0xA6.
- R4: In program mode (`hv_supply` = 1, `hv_a9` = 0, `cen_n` = 0, `oen_n` = 1), a strobe held low for at least `PROG_CYC` sampled cycles updates the byte at the address present at the falling edge when the strobe is released.
- R5: A completed program stores the old byte bitwise ANDed with the data present at the falling edge, so a program never sets a bit.
- R6: A program strobe released after fewer than `PROG_CYC` sampled low cycles leaves the byte unchanged.
- R7: In erase mode (`hv_supply` = 1, `hv_a9` = 1, `cen_n` = 0), a strobe held low for at least `ERASE_CYC` cycles sets every byte to 0xFF when released, whatever the address and data inputs do.
- R8: An erase strobe released after fewer than `ERASE_CYC` sampled low cycles leaves every byte unchanged.
- R9: `busy` rises in the cycle after a strobe falling edge is sampled in program or erase mode, and falls in the cycle after the strobe is sampled high.
- R10: After reset every byte reads 0xFF, `busy` is 0 and `dq_oe` is 0 while deselected.
- R11: A strobe pulse while `hv_supply` = 1 and `oen_n` = 0 with `hv_a9` = 0 (inhibited) changes no stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used for strobe sampling and pulse timing |
| rst_n | input | 1 | Active-low asynchronous reset |
| cen_n | input | 1 | Chip select, active low |
| oen_n | input | 1 | Read enable, active low |
| pstb_n | input | 1 | Program and erase strobe, active low |
| hv_supply | input | 1 | High voltage present on the programming supply pin |
| hv_a9 | input | 1 | High voltage present on address line 9 |
| addr | input | ADDR_W | Byte address |
| dq_in | input | 8 | Data bus as driven by the programmer |
| dq_out | output | 8 | Data the block drives onto the bus |
| dq_oe | output | 1 | Bus drive enable for dq_out |
| busy | output | 1 | A program or erase pulse is being timed |

## Verification
The hardest case to reach is an erase pulse that stops exactly one cycle short of its minimum length. This cycle has to be set up on an array that already holds cleared bits, because otherwise the shortfall cannot be seen. The stimulus first programs a pattern through the full-length program path. It then gives a strobe of `ERASE_CYC - 1` sampled cycles and reads the pattern back. After that, a full-length erase is applied while the address and data inputs keep toggling, and every byte is read back as 0xFF.

// File: rtl/mtp_pkg.sv
package mtp_pkg;
    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_READ,
        MD_IDENT,
        MD_PROG,
        MD_ERASE,
        MD_INHIBIT
    } mtp_mode_e;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_PROG,
        PS_ERASE
    } pulse_state_e;

    localparam logic [7:0] MFR_CODE = 8'hBF;
endpackage

// File: rtl/mtp_mode_dec.sv
module mtp_mode_dec
    import mtp_pkg::*;
(
    input  logic      cen_n,
    input  logic      oen_n,
    input  logic      hv_supply,
    input  logic      hv_a9,
    output mtp_mode_e mode,
    output logic      drive_en
);
    always_comb begin
        if (cen_n)
            mode = MD_STANDBY;
        else if (hv_supply && hv_a9)
            mode = MD_ERASE;
        else if (hv_supply && oen_n)
            mode = MD_PROG;
        else if (hv_supply)
            mode = MD_INHIBIT;
        else if (hv_a9)
            mode = MD_IDENT;
        else
            mode = MD_READ;
    end

    assign drive_en = ((mode == MD_READ) || (mode == MD_IDENT)) && !oen_n;
endmodule

// File: rtl/mtp_pulse_ctl.sv
module mtp_pulse_ctl
    import mtp_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int PROG_CYC  = 20,
    parameter int ERASE_CYC = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mtp_mode_e         mode,
    input  logic              pstb_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic              wr_fire,
    output logic              erase_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              busy
);
    localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(MAX_CYC);
    localparam logic [CNT_W-1:0] PROG_MIN = CNT_W'(PROG_CYC);
    localparam logic [CNT_W-1:0] ERS_MIN  = CNT_W'(ERASE_CYC);

    typedef struct packed {
        pulse_state_e      st;
        logic [CNT_W-1:0]  cnt;
        logic              stb;
        logic [ADDR_W-1:0] a;
        logic [7:0]        d;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic fall;

    assign fall = ctl_q.stb && !pstb_n;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.stb  = pstb_n;
        wr_fire    = 1'b0;
        erase_fire = 1'b0;
        unique case (ctl_q.st)
            PS_IDLE: begin
                if (fall && (mode == MD_PROG)) begin
                    ctl_d.st  = PS_PROG;
                    ctl_d.cnt = CNT_W'(1);
                    ctl_d.a   = addr;
                    ctl_d.d   = din;
                end else if (fall && (mode == MD_ERASE)) begin
                    ctl_d.st  = PS_ERASE;
                    ctl_d.cnt = CNT_W'(1);
                end
            end
            PS_PROG, PS_ERASE: begin
                if (pstb_n) begin
                    ctl_d.st = PS_IDLE;
                    if (ctl_q.st == PS_PROG)
                        wr_fire = (ctl_q.cnt >= PROG_MIN);
                    else
                        erase_fire = (ctl_q.cnt >= ERS_MIN);
                end else if ((ctl_q.st == PS_PROG && mode != MD_PROG) ||
                             (ctl_q.st == PS_ERASE && mode != MD_ERASE)) begin
                    ctl_d.st = PS_IDLE;
                end else if (ctl_q.cnt != CNT_SAT) begin
                    ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                end
            end
            default: ctl_d.st = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q     <= '0;
            ctl_q.st  <= PS_IDLE;
            ctl_q.stb <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wr_addr = ctl_q.a;
    assign wr_data = ctl_q.d;
    assign busy    = (ctl_q.st != PS_IDLE);
endmodule

// File: rtl/mtp_array.sv
module mtp_array #(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic              erase_fire,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_d [DEPTH];
    logic [7:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (erase_fire)
                mem_d[i] = 8'hFF;
            else if (wr_fire && (wr_addr == ADDR_W'(i)))
                mem_d[i] = mem_q[i] & wr_data;
            else
                mem_d[i] = mem_q[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/mtp_byte_store.sv
module mtp_byte_store
    import mtp_pkg::*;
#(
    parameter int         ADDR_W    = 6,
    parameter logic [7:0] DEV_CODE  = 8'hA5,
    parameter int         PROG_CYC  = 20,
    parameter int         ERASE_CYC = 100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cen_n,
    input  logic              oen_n,
    input  logic              pstb_n,
    input  logic              hv_supply,
    input  logic              hv_a9,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_in,
    output logic [7:0]        dq_out,
    output logic              dq_oe,
    output logic              busy
);
    generate
        if (DEV_CODE != 8'hA4 && DEV_CODE != 8'hA5 && DEV_CODE != 8'hA6) begin : g_bad_code
            $error("DEV_CODE must be one of 0xA4, 0xA5, 0xA6");
        end
    endgenerate

    mtp_mode_e         mode;
    logic              wr_fire, erase_fire;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data, rd_data;

    mtp_mode_dec u_dec (
        .cen_n     (cen_n),
        .oen_n     (oen_n),
        .hv_supply (hv_supply),
        .hv_a9     (hv_a9),
        .mode      (mode),
        .drive_en  (dq_oe)
    );

    mtp_pulse_ctl #(
        .ADDR_W    (ADDR_W),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .pstb_n     (pstb_n),
        .addr       (addr),
        .din        (dq_in),
        .wr_fire    (wr_fire),
        .erase_fire (erase_fire),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .busy       (busy)
    );

    mtp_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_fire    (wr_fire),
        .erase_fire (erase_fire),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (addr),
        .rd_data    (rd_data)
    );

    always_comb begin
        if (mode == MD_IDENT)
            dq_out = addr[0] ? DEV_CODE : MFR_CODE;
        else
            dq_out = rd_data;
    end
endmodule

// File: rtl/mtp_byte_store_chk.sv
module mtp_byte_store_chk #(
    parameter int         ADDR_W   = 6,
    parameter logic [7:0] DEV_CODE = 8'hA5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cen_n,
    input logic              oen_n,
    input logic              pstb_n,
    input logic              hv_supply,
    input logic              hv_a9,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        dq_out,
    input logic              dq_oe,
    input logic              busy
);
    p_bus_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (!cen_n && !oen_n && !hv_supply));

    p_standby_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> !busy);

    p_ident_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && !oen_n && hv_a9 && !hv_supply) |->
        (dq_out == (addr[0] ? DEV_CODE : 8'hBF)));

    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $fell(pstb_n) && !cen_n && hv_supply && (hv_a9 || oen_n)) |=> busy);

    p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && pstb_n) |=> !busy);
endmodule

bind mtp_byte_store mtp_byte_store_chk #(
    .ADDR_W   (ADDR_W),
    .DEV_CODE (DEV_CODE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cen_n     (cen_n),
    .oen_n     (oen_n),
    .pstb_n    (pstb_n),
    .hv_supply (hv_supply),
    .hv_a9     (hv_a9),
    .addr      (addr),
    .dq_out    (dq_out),
    .dq_oe     (dq_oe),
    .busy      (busy)
);

// File: tb/mtp_byte_store_tb.sv
module mtp_byte_store_tb_top;
    localparam int         AW    = 6;
    localparam int         DEPTH = 1 << AW;
    localparam logic [7:0] DEV   = 8'hA5;
    localparam int         PCYC  = 20;
    localparam int         ECYC  = 100;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cen_n = 1'b1, oen_n = 1'b1, pstb_n = 1'b1;
    logic          hv_supply = 1'b0, hv_a9 = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    dq_in = '0;
    logic [7:0]    dq_out;
    logic          dq_oe, busy;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [DEPTH];

    always #2 clk = ~clk;

    mtp_byte_store #(
        .ADDR_W(AW), .DEV_CODE(DEV), .PROG_CYC(PCYC), .ERASE_CYC(ECYC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .oen_n(oen_n), .pstb_n(pstb_n),
        .hv_supply(hv_supply), .hv_a9(hv_a9), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic set_read();
        @(negedge clk);
        hv_supply = 1'b0; hv_a9 = 1'b0; cen_n = 1'b0; oen_n = 1'b0; pstb_n = 1'b1;
    endtask

    task automatic read_chk(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        check(req, dq_out, exp);
    endtask

    // strobe low for n sampled edges, then released; commit lands on the release edge
    task automatic strobe(input int n, input bit scramble);
        @(negedge clk);
        pstb_n = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == 1) check("R9 busy during pulse", {7'd0, busy}, 8'h01);
            if (scramble) begin addr = AW'(i * 7); dq_in = 8'(i * 13); end
        end
        pstb_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R9 busy after release", {7'd0, busy}, 8'h00);
    endtask

    task automatic program_byte(input logic [AW-1:0] a, input logic [7:0] d, input int n);
        @(negedge clk);
        hv_a9 = 1'b0; hv_supply = 1'b1; cen_n = 1'b0; oen_n = 1'b1;
        addr = a; dq_in = d;
        strobe(n, 1'b0);
        if (n >= PCYC) model[a] = model[a] & d;
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        check("R10 busy after reset", {7'd0, busy}, 8'h00);
        check("R10 released when deselected", {7'd0, dq_oe}, 8'h00);
        set_read();
        for (int i = 0; i < DEPTH; i += 9) read_chk("R10 erased after reset", AW'(i), 8'hFF);
    endtask

    task automatic t_bus_gate();
        set_read();
        #1; check("R1 drive on read", {7'd0, dq_oe}, 8'h01);
        oen_n = 1'b1; #1; check("R1 release oen high", {7'd0, dq_oe}, 8'h00);
        oen_n = 1'b0; cen_n = 1'b1; #1; check("R1 release cen high", {7'd0, dq_oe}, 8'h00);
        cen_n = 1'b0; hv_supply = 1'b1; #1; check("R1 release supply hv", {7'd0, dq_oe}, 8'h00);
        hv_supply = 1'b0;
    endtask

    task automatic t_ident();
        set_read();
        hv_a9 = 1'b1;
        read_chk("R3 maker code", AW'(0), 8'hBF);
        read_chk("R3 device code", AW'(1), DEV);
        read_chk("R3 maker code high addr", AW'(6), 8'hBF);
        read_chk("R3 device code high addr", AW'(7), DEV);
        hv_a9 = 1'b0;
    endtask

    task automatic t_program();
        program_byte(AW'(3), 8'h5A, PCYC);
        program_byte(AW'(10), 8'h00, PCYC + 5);
        program_byte(AW'(63), 8'hC3, PCYC);
        set_read();
        read_chk("R4 program addr 3", AW'(3), 8'h5A);
        read_chk("R4 program addr 10", AW'(10), 8'h00);
        read_chk("R4 program addr 63", AW'(63), 8'hC3);
        read_chk("R4 neighbour untouched", AW'(4), 8'hFF);
    endtask

    task automatic t_and();
        program_byte(AW'(3), 8'hF0, PCYC);
        program_byte(AW'(63), 8'hFF, PCYC);
        set_read();
        read_chk("R5 clears only", AW'(3), 8'h50);
        read_chk("R5 no bit set", AW'(63), 8'hC3);
    endtask

    task automatic t_short();
        program_byte(AW'(4), 8'h00, PCYC - 1);
        program_byte(AW'(3), 8'h00, 1);
        set_read();
        read_chk("R6 short pulse fresh byte", AW'(4), 8'hFF);
        read_chk("R6 short pulse old byte", AW'(3), 8'h50);
    endtask

    task automatic t_standby();
        @(negedge clk);
        hv_supply = 1'b1; hv_a9 = 1'b0; cen_n = 1'b1; oen_n = 1'b1;
        addr = AW'(5); dq_in = 8'h00;
        pstb_n = 1'b0;
        repeat (PCYC + 2) @(negedge clk);
        check("R2 no busy in standby", {7'd0, busy}, 8'h00);
        pstb_n = 1'b1;
        @(negedge clk);
        hv_a9 = 1'b1;
        pstb_n = 1'b0;
        repeat (ECYC + 2) @(negedge clk);
        pstb_n = 1'b1;
        set_read();
        read_chk("R2 standby program ignored", AW'(5), 8'hFF);
        read_chk("R2 standby erase ignored", AW'(3), 8'h50);
    endtask

    task automatic t_inhibit();
        @(negedge clk);
        hv_supply = 1'b1; hv_a9 = 1'b0; cen_n = 1'b0; oen_n = 1'b0;
        addr = AW'(6); dq_in = 8'h0F;
        pstb_n = 1'b0;
        repeat (PCYC + 2) @(negedge clk);
        check("R11 no busy when inhibited", {7'd0, busy}, 8'h00);
        pstb_n = 1'b1;
        set_read();
        read_chk("R11 inhibited byte unchanged", AW'(6), 8'hFF);
    endtask

    task automatic t_erase_short();
        @(negedge clk);
        hv_supply = 1'b1; hv_a9 = 1'b1; cen_n = 1'b0; oen_n = 1'b1;
        strobe(ECYC - 1, 1'b1);
        set_read();
        read_chk("R8 short erase addr 3", AW'(3), 8'h50);
        read_chk("R8 short erase addr 10", AW'(10), 8'h00);
        read_chk("R8 short erase addr 63", AW'(63), 8'hC3);
    endtask

    task automatic t_erase();
        @(negedge clk);
        hv_supply = 1'b1; hv_a9 = 1'b1; cen_n = 1'b0; oen_n = 1'b1;
        strobe(ECYC, 1'b1);
        set_read();
        for (int i = 0; i < DEPTH; i++) read_chk("R7 erase all bytes", AW'(i), 8'hFF);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_bus_gate();
        t_ident();
        t_program();
        t_and();
        t_short();
        t_standby();
        t_inhibit();
        set_read();
        read_chk("R4 model addr 10", AW'(10), model[10]);
        t_erase_short();
        t_erase();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule